// File: doc/BRIEF.md
# Oversampled Serial Slave Front End

This block is the shifting front end of a synchronous serial slave. It runs entirely on a fast local clock. It treats the external serial clock, chip select and data-in line as asynchronous inputs. Each of them is passed through a two-flop synchronizer. The serial clock and chip select then go through one extra delay flop. Edges are found by comparing the delayed copy with the synchronized copy. A rising edge of the serial clock captures one receive bit. A falling edge moves the transmit line to its next bit. Both directions shift the most significant bit first.

Transmit words come from a small queue. Software or a neighbouring block can fill the queue at any time, including while the block is disabled, so that it is primed before shifting starts. The word at the head of the queue is placed on the data-out line as soon as a frame opens, or as soon as the previous word in the frame ends. That word is removed from the queue only when the master clocks its first bit. The word length is set by a length code and can be 4 to 16 bits. Each completed receive word is presented with a one-cycle strobe.

The local clock must run at least 12 times faster than the fastest serial clock the master will use. At that ratio, the three-cycle edge latency still leaves the next transmit bit settled before the master samples it.

Top module: `spiSlaveFront`

## Requirements
- R1: After reset the block is disabled: `rxValid`, `underrun`, `misoOe` and `miso` are all 0.
- R2: `rxValid` goes high on exactly the third rising edge of `clk` after the serial clock rises for the last bit of a word.
- R3: Received bits are taken on serial-clock rising edges, most significant bit first. The word length is `lenCode`+1 bits; codes below 3 act as 3. `rxWord` holds the word right-aligned with its upper bits zero.
- R4: While a word is shifting, `miso` carries bit `lenCode` of the transmit word first. It moves to the next lower bit after each serial-clock falling edge, so the master receives the word most significant bit first.
- R5: `rxValid` is a one-cycle pulse, issued once per completed word.
- R6: When chip select (`csN`, active low) is released, the bit counter clears, and `misoOe` and `miso` go to 0 once the release has passed synchronization. A released frame never produces `rxValid`, and the next frame starts from its first bit.
- R7: The transmit queue holds up to 8 words and accepts `txPush` whether or not the block is enabled. A push while the queue is full is dropped.
- R8: If the queue is empty when a word begins shifting, that word is sent as all zeros and `underrun` pulses for one cycle.
- R9: While `enable` is 0, serial-clock activity has no effect: `misoOe` stays 0, no `rxValid` is issued and the queue keeps its contents.
- R10: Several words can follow each other inside one frame. Each word draws the next queue entry. An entry is consumed only when the master clocks the first bit of its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 holds the serial side idle |
| lenCode | input | 4 | Word length minus one (3..15) |
| txPush | input | 1 | Write strobe for the transmit queue |
| txData | input | 16 | Transmit word to enqueue |
| sclk | input | 1 | External serial clock (asynchronous) |
| csN | input | 1 | External chip select, active low (asynchronous) |
| mosi | input | 1 | Serial data from the master (asynchronous) |
| miso | output | 1 | Serial data to the master |
| misoOe | output | 1 | Drive enable for `miso` |
| rxValid | output | 1 | One-cycle strobe for a completed receive word |
| rxWord | output | 16 | Last received word, right-aligned |
| underrun | output | 1 | One-cycle strobe: a word started with the queue empty |

## Verification
The embedded properties check on every cycle the following rules:
- the receive and underrun strobes last exactly one cycle;
- the bit counter clears whenever the frame is inactive and never runs past the word length;
- the queue occupancy never exceeds its depth, and a push into a full queue leaves the occupancy unchanged;
- a disabled block never raises a receive strobe.

Only the bench's scenarios can show the following:
- the exact three-cycle latency from a serial edge;
- the bit order and length masking of received and transmitted words;
- priming while disabled;
- an entry surviving an idle frame but not an aborted one;
- back-to-back words within a frame;
- the zero word sent on an underrun.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  // Strobes from the edge/count control to the shifting datapath
  typedef struct packed {
    logic active;    // frame open and block enabled
    logic load;      // fetch queue head into transmit shifter
    logic shiftTx;   // advance transmit shifter
    logic shiftRx;   // capture one receive bit
    logic firstBit;  // capture of bit 0 of a word
    logic wordEnd;   // capture of the last bit of a word
  } frontCtl_t;

  localparam int MIN_LEN_CODE = 3;

endpackage

// File: rtl/spiTxQueue.sv
module spiTxQueue #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic          full, doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = store[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  // R7: occupancy bounded and full pushes dropped
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/spiFrontCtl.sv
module spiFrontCtl
  import spi_front_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             sclk,
  input  logic             csN,
  output frontCtl_t        ctl,
  output logic [LEN_W-1:0] lenEff
);
  // three flops each: two to synchronize, one to delay for edge compare
  logic [2:0] sclkPipe, csPipe;
  logic       activeQ, pending;
  logic [LEN_W-1:0] bitCnt;
  logic       active, rise, fall, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
    end else begin
      sclkPipe <= {sclkPipe[1:0], sclk};
      csPipe   <= {csPipe[1:0], csN};
    end
  end

  assign lenEff  = (lenCode < LEN_W'(MIN_LEN_CODE)) ? LEN_W'(MIN_LEN_CODE) : lenCode;
  assign active  = enable && !csPipe[1];
  assign rise    = active &&  sclkPipe[1] && !sclkPipe[2];
  assign fall    = active && !sclkPipe[1] &&  sclkPipe[2];
  assign lastBit = (bitCnt == lenEff);

  always_comb begin
    ctl          = '0;
    ctl.active   = active;
    ctl.load     = (active && !activeQ) || (fall && pending);
    ctl.shiftTx  = fall && !pending && (bitCnt != '0);
    ctl.shiftRx  = rise;
    ctl.firstBit = rise && (bitCnt == '0);
    ctl.wordEnd  = rise && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      pending <= 1'b0;
      bitCnt  <= '0;
    end else begin
      activeQ <= active;
      if (!active) begin
        bitCnt  <= '0;
        pending <= 1'b0;
      end else begin
        if (rise) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
        if (rise && lastBit)     pending <= 1'b1;
        else if (fall && pending) pending <= 1'b0;
      end
    end
  end

  // R6: counter cleared whenever the frame is closed
  a_r6_idle_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (bitCnt == '0));
  // R3: counter never passes the configured length
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    $stable(lenCode) |-> (bitCnt <= lenEff));

endmodule

// File: rtl/spiFrontDp.sv
module spiFrontDp
  import spi_front_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  frontCtl_t        ctl,
  input  logic [LEN_W-1:0] lenEff,
  input  logic             mosi,
  input  logic [W-1:0]     qHead,
  input  logic             qEmpty,
  output logic             qPop,
  output logic             miso,
  output logic             misoOe,
  output logic             rxValid,
  output logic [W-1:0]     rxWord,
  output logic             underrun
);
  logic [1:0]     mosiSync;
  logic [W-1:0]   rxShift, rxNext, txShift, rxMask;
  logic [W:0]     maskWide;
  logic [LEN_W:0] nBits;
  logic           fromQueue;

  assign nBits    = {1'b0, lenEff} + 1'b1;
  assign maskWide = ((W+1)'(1) << nBits) - (W+1)'(1);
  assign rxMask   = maskWide[W-1:0];
  assign rxNext   = {rxShift[W-2:0], mosiSync[1]};

  assign qPop   = ctl.firstBit && fromQueue;
  assign misoOe = ctl.active;
  assign miso   = ctl.active && txShift[lenEff];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mosiSync  <= '0;
      rxShift   <= '0;
      rxWord    <= '0;
      rxValid   <= 1'b0;
      txShift   <= '0;
      fromQueue <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      mosiSync <= {mosiSync[0], mosi};
      rxValid  <= ctl.wordEnd;
      underrun <= ctl.firstBit && !fromQueue;
      if (ctl.shiftRx) rxShift <= rxNext;
      if (ctl.wordEnd) rxWord  <= rxNext & rxMask;
      if (!ctl.active) begin
        txShift   <= '0;
        fromQueue <= 1'b0;
      end else if (ctl.load) begin
        txShift   <= qEmpty ? '0 : qHead;
        fromQueue <= !qEmpty;
      end else if (ctl.shiftTx) begin
        txShift   <= {txShift[W-2:0], 1'b0};
      end
    end
  end

  // R5: receive strobe lasts one cycle
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  // R8: underrun strobe lasts one cycle
  a_r8_underrun_single: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);

endmodule

// File: rtl/spiSlaveFront.sv
module spiSlaveFront
  import spi_front_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic [$clog2(DATA_W)-1:0]  lenCode,
  input  logic                       txPush,
  input  logic [DATA_W-1:0]          txData,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       mosi,
  output logic                       miso,
  output logic                       misoOe,
  output logic                       rxValid,
  output logic [DATA_W-1:0]          rxWord,
  output logic                       underrun
);
  localparam int LEN_W = $clog2(DATA_W);

  frontCtl_t         ctl;
  logic [LEN_W-1:0]  lenEff;
  logic [DATA_W-1:0] qHead;
  logic              qEmpty, qPop;

  spiFrontCtl #(.LEN_W(LEN_W)) uCtl (
    .clk(clk), .rstN(rstN), .enable(enable), .lenCode(lenCode),
    .sclk(sclk), .csN(csN), .ctl(ctl), .lenEff(lenEff)
  );

  spiTxQueue #(.W(DATA_W), .DEPTH(DEPTH)) uQueue (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(txData),
    .pop(qPop), .head(qHead), .empty(qEmpty)
  );

  spiFrontDp #(.W(DATA_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lenEff(lenEff), .mosi(mosi),
    .qHead(qHead), .qEmpty(qEmpty), .qPop(qPop), .miso(miso),
    .misoOe(misoOe), .rxValid(rxValid), .rxWord(rxWord), .underrun(underrun)
  );

  // R9: disabled block never reports a word
  a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !rxValid);

endmodule

// File: tb/sim_spiSlaveFront.sv
module sim_spiSlaveFront;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  lenCode = 4'd7;
  logic        txPush = 1'b0;
  logic [15:0] txData = '0;
  logic        sclk = 1'b0;
  logic        csN = 1'b1;
  logic        mosi = 1'b0;
  logic        miso, misoOe, rxValid, underrun;
  logic [15:0] rxWord;

  int checks = 0;
  int errors = 0;
  int rxCount = 0;
  int urCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spiSlaveFront u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .lenCode(lenCode),
    .txPush(txPush), .txData(txData), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .misoOe(misoOe), .rxValid(rxValid), .rxWord(rxWord),
    .underrun(underrun)
  );

  always @(posedge clk) begin
    if (rxValid)  rxCount <= rxCount + 1;
    if (underrun) urCount <= urCount + 1;
  end

  // {lenCode, master word, queued transmit word}
  localparam logic [35:0] VEC [0:5] = '{
    {4'd7,  16'h00A5, 16'h003C},
    {4'd15, 16'hC3E1, 16'h8421},
    {4'd3,  16'h0009, 16'hFFF6},
    {4'd11, 16'h0F0F, 16'hA5A5},
    {4'd0,  16'h000D, 16'h0002},
    {4'd9,  16'h03FF, 16'h0155}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk);
    txPush = 1'b1;
    txData = v;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic shiftWord(input int n, input logic [15:0] w, output logic [15:0] got);
    got = '0;
    for (int b = n - 1; b >= 0; b--) begin
      mosi = w[b];
      repeat (8) @(negedge clk);
      got[b] = miso;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic openFrame();
    csN = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic closeFrame();
    repeat (8) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [15:0] maskOf(input logic [3:0] code);
    int n;
    n = (code < 4'd3) ? 4 : int'(code) + 1;
    return 16'((32'd1 << n) - 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    int rxBefore, urBefore;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 rxValid", rxValid, 0);
    check("R1 underrun", underrun, 0);
    check("R1 misoOe", misoOe, 0);
    check("R1 miso", miso, 0);

    // R9 / R7: disabled block ignores a frame; queue primed while disabled
    push(16'h1234);
    lenCode = 4'd7;
    rxBefore = rxCount;
    openFrame();
    check("R9 misoOe disabled", misoOe, 0);
    shiftWord(8, 16'h00FF, got);
    closeFrame();
    check("R9 no rxValid disabled", rxCount, rxBefore);
    check("R9 miso idle disabled", got, 0);

    // R7: primed word survives and is sent after enabling
    enable = 1'b1;
    lenCode = 4'd15;
    openFrame();
    check("R6 misoOe in frame", misoOe, 1);
    shiftWord(16, 16'h5AA5, got);
    closeFrame();
    check("R7 primed word sent", got, 16'h1234);
    check("R3 rx 16 bit", rxWord, 16'h5AA5);

    // R3/R4/R5: table of lengths and patterns
    for (int i = 0; i < 6; i++) begin
      logic [3:0]  code;
      logic [15:0] mw, tw;
      int n;
      {code, mw, tw} = VEC[i];
      n = (code < 4'd3) ? 4 : int'(code) + 1;
      lenCode = code;
      push(tw);
      rxBefore = rxCount;
      urBefore = urCount;
      openFrame();
      shiftWord(n, mw, got);
      closeFrame();
      check("R3 rx word", rxWord, mw & maskOf(code));
      check("R4 tx word", got, tw & maskOf(code));
      check("R5 one strobe", rxCount, rxBefore + 1);
      check("R8 no underrun", urCount, urBefore);
    end

    // R2 / R8: latency of the strobe, and an empty-queue word
    lenCode = 4'd3;
    urBefore = urCount;
    openFrame();
    for (int b = 3; b >= 0; b--) begin
      mosi = b[0] ? 1'b1 : 1'b0;
      repeat (8) @(negedge clk);
      check("R8 zero bit", miso, 0);
      sclk = 1'b1;
      if (b == 0) begin
        @(negedge clk); check("R2 not after 1", rxValid, 0);
        @(negedge clk); check("R2 not after 2", rxValid, 0);
        @(negedge clk); check("R2 high after 3", rxValid, 1);
        @(negedge clk); check("R5 low after pulse", rxValid, 0);
        repeat (4) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      sclk = 1'b0;
    end
    closeFrame();
    check("R2 word", rxWord, 16'h000A);
    check("R8 underrun pulse", urCount, urBefore + 1);

    // R6: abort a word part way, then a clean frame
    lenCode = 4'd7;
    push(16'hBEEF);
    rxBefore = rxCount;
    openFrame();
    shiftWord(3, 16'h0007, got);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 misoOe released", misoOe, 0);
    check("R6 miso released", miso, 0);
    check("R6 no strobe on abort", rxCount, rxBefore);
    push(16'h00C3);
    openFrame();
    shiftWord(8, 16'h005A, got);
    closeFrame();
    check("R6 restart rx", rxWord, 16'h005A);
    check("R6 restart tx", got, 16'h00C3);

    // R10: two words back to back in one frame
    push(16'h0011);
    push(16'h0022);
    rxBefore = rxCount;
    urBefore = urCount;
    openFrame();
    shiftWord(8, 16'h0081, got);
    check("R10 first tx", got, 16'h0011);
    repeat (4) @(negedge clk);
    check("R10 first rx", rxWord, 16'h0081);
    shiftWord(8, 16'h0042, got);
    closeFrame();
    check("R10 second tx", got, 16'h0022);
    check("R10 second rx", rxWord, 16'h0042);
    check("R10 two strobes", rxCount, rxBefore + 2);
    check("R10 no underrun", urCount, urBefore);

    // R7: fill while disabled, ninth push dropped
    enable = 1'b0;
    for (int k = 1; k <= 9; k++) push(16'(k));
    enable = 1'b1;
    lenCode = 4'd3;
    urBefore = urCount;
    for (int k = 1; k <= 9; k++) begin
      openFrame();
      shiftWord(4, 16'h0000, got);
      closeFrame();
      check("R7 queue order", got, (k <= 8) ? 32'(k) : 32'd0);
    end
    check("R7 full push dropped", urCount, urBefore + 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule